// File: doc/BRIEF.md
# Serial DAC Word Loader

This block is the host side of a link to a 16-bit serial DAC. A sample word arrives on a valid/ready handshake. The block sends it out on a data line and a serial clock, and it frames the transfer with a select line. Clock polarity and phase are both zero. The DAC treats the serial clock as its shift strobe and the select line as its load strobe. The rising edge of select, after exactly sixteen clocked bits, moves the word from the DAC's input register into its output register.

Each word goes out as the upper byte and then the lower byte, MSB first in each, inside one select-low window. The parameter `HALF_DIV` sets the length of each serial clock phase in system clock cycles. `SEL_GAP` sets the minimum time select stays high between words. With a 50 MHz system clock, the defaults give 40 ns phases (80 ns period) and at least 80 ns of select-high time.

Top module: `dac_spi_host`

## Requirements
- R1: While `rst_n` is low, `load_sel` is 1, `ser_clk` is 0 and `word_ready` is 0. After reset is released, `word_ready` rises within `SEL_GAP`+2 cycles.
- R2: A word is taken on a clock edge where `word_valid` and `word_ready` are both 1. `word_ready` is 0 from the next cycle and stays 0 for as long as `load_sel` is low.
- R3: `load_sel` falls in the cycle after acceptance. It stays low for exactly `HALF_DIV` cycles before the first rising edge of `ser_clk`.
- R4: `ser_clk` is 0 whenever `load_sel` is 1, so the clock idles low.
- R5: Each select-low window carries exactly 16 rising edges of `ser_clk`, which is 8 per byte.
- R6: The bits at the rising edges are word bits 15 down to 0 in that order: the upper byte first, then the lower byte, each MSB first.
- R7: `ser_dat` changes only in the cycle where `ser_clk` falls. It is stable through every high phase.
- R8: Every high phase of `ser_clk`, and every low phase between two bits, lasts exactly `HALF_DIV` cycles. The default gives at least 30 ns per phase and at least 80 ns per period at 50 MHz.
- R9: `load_sel` rises exactly `HALF_DIV` cycles after the last falling edge of `ser_clk`. That rising edge commits the word.
- R10: `load_sel` stays high for at least `SEL_GAP` cycles between two words, and `word_ready` stays 0 until that time has passed.
- R11: `word_valid` and `word_data` have no effect while `word_ready` is 0. No extra frame is sent, and the word in flight is not altered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| word_valid | input | 1 | Sample word offered |
| word_ready | output | 1 | Block can take a word |
| word_data | input | 16 | Sample word |
| ser_clk | output | 1 | Serial clock (DAC shift strobe) |
| ser_dat | output | 1 | Serial data |
| load_sel | output | 1 | Select, low during transfer; its rising edge loads the DAC |

## Verification
The hardest situation to reach is a new word being offered while a frame is still in progress. It has to be offered both mid-frame and right as the select-high gap ends. The stimulus holds `word_valid` high with junk data during a transfer, and it also issues back-to-back words with no idle time between them. This checks that the junk never reaches the serial line, and that the gap before the next select fall is still respected. Patterns that sit at the byte boundary (0x8000, 0x7FFF, 0x00FF, 0xFF00) show whether the two bytes are put in the right order.

// File: rtl/dac_spi_pkg.sv
package dac_spi_pkg;

  typedef enum logic [2:0] {
    S_GAP,
    S_IDLE,
    S_SETUP,
    S_HIGH,
    S_LOW,
    S_TAIL
  } xfer_state_t;

  // larger of two counts, used to size the shared phase timer
  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

  // timer reload value for a span of n cycles
  function automatic int unsigned span_reload(input int unsigned n);
    return (n == 0) ? 0 : n - 1;
  endfunction

endpackage

// File: rtl/dac_spi_timer.sv
module dac_spi_timer #(
  parameter int unsigned TW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [TW-1:0] load_val,
  output logic          expire
);
  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)             cnt_q <= '0;
    else if (load)          cnt_q <= load_val;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign expire = (cnt_q == '0);
endmodule

// File: rtl/dac_spi_shifter.sv
module dac_spi_shifter #(
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] load_word,
  input  logic              shift,
  output logic              bit_out,
  output logic              last_bit
);
  localparam int unsigned IW = $clog2(DATA_W);

  logic [DATA_W-1:0] sreg_q;
  logic [IW-1:0]     idx_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sreg_q <= '0;
      idx_q  <= '0;
    end else if (load) begin
      sreg_q <= load_word;
      idx_q  <= '0;
    end else if (shift) begin
      sreg_q <= {sreg_q[DATA_W-2:0], 1'b0};
      idx_q  <= idx_q + 1'b1;
    end
  end

  // upper byte leaves first because the word is loaded unchanged and shifted left
  assign bit_out  = sreg_q[DATA_W-1];
  assign last_bit = (idx_q == IW'(DATA_W - 1));
endmodule

// File: rtl/dac_spi_ctrl.sv
module dac_spi_ctrl
  import dac_spi_pkg::*;
#(
  parameter int unsigned HALF_DIV = 2,
  parameter int unsigned SEL_GAP  = 4,
  parameter int unsigned TW       = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic          tmr_expire,
  input  logic          last_bit,
  output logic          tmr_load,
  output logic [TW-1:0] tmr_val,
  output logic          sh_load,
  output logic          sh_shift,
  output logic          sclk,
  output logic          sel
);
  localparam logic [TW-1:0] PH_RELOAD  = TW'(span_reload(HALF_DIV));
  localparam logic [TW-1:0] GAP_RELOAD = TW'(span_reload(SEL_GAP));

  xfer_state_t st_q, st_n;
  logic sclk_q, sclk_n, sel_q, sel_n;

  always_comb begin
    st_n     = st_q;
    sclk_n   = sclk_q;
    sel_n    = sel_q;
    tmr_load = 1'b0;
    tmr_val  = PH_RELOAD;
    sh_load  = 1'b0;
    sh_shift = 1'b0;
    unique case (st_q)
      S_IDLE: if (in_valid) begin
        sh_load  = 1'b1;
        sel_n    = 1'b0;
        tmr_load = 1'b1;
        st_n     = S_SETUP;
      end
      S_SETUP: if (tmr_expire) begin
        sclk_n   = 1'b1;
        tmr_load = 1'b1;
        st_n     = S_HIGH;
      end
      S_HIGH: if (tmr_expire) begin
        sclk_n   = 1'b0;
        tmr_load = 1'b1;
        if (last_bit) st_n = S_TAIL;
        else begin
          sh_shift = 1'b1;
          st_n     = S_LOW;
        end
      end
      S_LOW: if (tmr_expire) begin
        sclk_n   = 1'b1;
        tmr_load = 1'b1;
        st_n     = S_HIGH;
      end
      S_TAIL: if (tmr_expire) begin
        sel_n    = 1'b1;
        tmr_load = 1'b1;
        tmr_val  = GAP_RELOAD;
        st_n     = S_GAP;
      end
      S_GAP: if (tmr_expire) st_n = S_IDLE;
      default: st_n = S_GAP;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= S_GAP;
      sclk_q <= 1'b0;
      sel_q  <= 1'b1;
    end else begin
      st_q   <= st_n;
      sclk_q <= sclk_n;
      sel_q  <= sel_n;
    end
  end

  assign in_ready = (st_q == S_IDLE);
  assign sclk     = sclk_q;
  assign sel      = sel_q;
endmodule

// File: rtl/dac_spi_host.sv
module dac_spi_host
  import dac_spi_pkg::*;
#(
  parameter int unsigned DATA_W   = 16,
  parameter int unsigned HALF_DIV = 2,
  parameter int unsigned SEL_GAP  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              word_valid,
  output logic              word_ready,
  input  logic [DATA_W-1:0] word_data,
  output logic              ser_clk,
  output logic              ser_dat,
  output logic              load_sel
);
  localparam int unsigned TW = $clog2(max2(HALF_DIV, SEL_GAP) + 1);

  logic          tmr_load, tmr_expire, last_bit, sh_load, sh_shift;
  logic [TW-1:0] tmr_val;

  // named events for the bound checker
  logic accept_evt;
  assign accept_evt = sh_load;

  dac_spi_ctrl #(.HALF_DIV(HALF_DIV), .SEL_GAP(SEL_GAP), .TW(TW)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .in_valid(word_valid), .in_ready(word_ready),
    .tmr_expire(tmr_expire), .last_bit(last_bit),
    .tmr_load(tmr_load), .tmr_val(tmr_val),
    .sh_load(sh_load), .sh_shift(sh_shift),
    .sclk(ser_clk), .sel(load_sel)
  );

  dac_spi_timer #(.TW(TW)) u_timer (
    .clk(clk), .rst_n(rst_n),
    .load(tmr_load), .load_val(tmr_val), .expire(tmr_expire)
  );

  dac_spi_shifter #(.DATA_W(DATA_W)) u_shift (
    .clk(clk), .rst_n(rst_n),
    .load(sh_load), .load_word(word_data), .shift(sh_shift),
    .bit_out(ser_dat), .last_bit(last_bit)
  );
endmodule

// File: rtl/dac_spi_host_chk.sv
module dac_spi_host_chk #(
  parameter int unsigned DATA_W   = 16,
  parameter int unsigned HALF_DIV = 2,
  parameter int unsigned SEL_GAP  = 4
) (
  input logic clk,
  input logic rst_n,
  input logic word_valid,
  input logic word_ready,
  input logic ser_clk,
  input logic ser_dat,
  input logic load_sel,
  input logic accept_evt
);
  localparam int unsigned CW = $clog2(HALF_DIV + SEL_GAP + 2) + 1;
  localparam int unsigned EW = $clog2(DATA_W + 1) + 1;

  logic          last_clk, last_sel;
  logic [CW-1:0] ph_cnt, hi_cnt;
  logic [EW-1:0] edges;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      last_clk <= 1'b0;
      last_sel <= 1'b1;
      ph_cnt   <= CW'(HALF_DIV);
      hi_cnt   <= CW'(SEL_GAP);
      edges    <= '0;
    end else begin
      last_clk <= ser_clk;
      last_sel <= load_sel;
      if (ser_clk != last_clk) ph_cnt <= CW'(1);
      else if (ph_cnt != '1)   ph_cnt <= ph_cnt + 1'b1;
      if (!load_sel)           hi_cnt <= '0;
      else if (hi_cnt != '1)   hi_cnt <= hi_cnt + 1'b1;
      if (!load_sel && last_sel)     edges <= '0;
      else if (ser_clk && !last_clk) edges <= edges + 1'b1;
    end
  end

  // R4
  idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_sel |-> !ser_clk);

  // R2
  busy_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !load_sel |-> !word_ready);

  // R3
  accept_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (word_valid && word_ready) |=> (!load_sel && !word_ready));

  // R2
  accept_evt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept_evt |-> (word_valid && word_ready));

  // R7
  dat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ser_clk && last_clk) |-> (ser_dat == $past(ser_dat)));

  // R8
  phase_min_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ser_clk != last_clk) |-> (ph_cnt >= CW'(HALF_DIV)));

  // R5
  bit_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load_sel && !last_sel) |-> (edges == EW'(DATA_W)));

  // R10
  gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    word_ready |-> (hi_cnt >= CW'(SEL_GAP)));
endmodule

bind dac_spi_host dac_spi_host_chk #(
  .DATA_W(DATA_W), .HALF_DIV(HALF_DIV), .SEL_GAP(SEL_GAP)
) u_chk (
  .clk(clk), .rst_n(rst_n), .word_valid(word_valid), .word_ready(word_ready),
  .ser_clk(ser_clk), .ser_dat(ser_dat), .load_sel(load_sel),
  .accept_evt(accept_evt)
);

// File: tb/dac_spi_host_test.sv
module dac_spi_host_test;
  localparam int HALF_DIV = 2;
  localparam int SEL_GAP  = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        word_valid = 1'b0;
  logic [15:0] word_data = '0;
  logic        word_ready, ser_clk, ser_dat, load_sel;

  always #10 clk = ~clk;  // 50 MHz

  dac_spi_host #(.DATA_W(16), .HALF_DIV(HALF_DIV), .SEL_GAP(SEL_GAP)) uut (
    .clk(clk), .rst_n(rst_n), .word_valid(word_valid), .word_ready(word_ready),
    .word_data(word_data), .ser_clk(ser_clk), .ser_dat(ser_dat), .load_sel(load_sel)
  );

  int checks = 0, errors = 0, sent = 0, frames = 0;
  bit done = 0;
  logic [15:0] exp_q[$];

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // driver: waits for ready, offers one word for one cycle, records it
  task automatic send_word(input logic [15:0] w);
    @(negedge clk);
    while (!word_ready) @(negedge clk);
    word_valid = 1'b1;
    word_data  = w;
    exp_q.push_back(w);
    sent++;
    @(negedge clk);
    word_valid = 1'b0;
    check(word_ready == 1'b0, "R2 ready low after accept", word_ready, 0);
    check(load_sel == 1'b0, "R3 select low after accept", load_sel, 0);
  endtask

  // monitor state
  logic        p_clk = 0, p_sel = 1, p_dat = 0;
  int          run = 1, sel_lo = 0, sel_hi = 100, nbits = 0;
  logic [15:0] cap = '0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (load_sel && ser_clk) check(0, "R4 clock high while idle", ser_clk, 0);
      if (!load_sel && word_ready) check(0, "R2 ready during frame", word_ready, 0);
      if (ser_clk && p_clk && ser_dat != p_dat) check(0, "R7 data moved in high phase", ser_dat, p_dat);
      // select edges
      if (!load_sel && p_sel) begin
        check(sel_hi >= SEL_GAP, "R10 select high time", sel_hi, SEL_GAP);
        sel_lo = 1; nbits = 0; cap = '0;
      end else if (!load_sel) sel_lo++;
      if (load_sel && !p_sel) begin
        frames++;
        check(nbits == 16, "R5 rising edges per frame", nbits, 16);
        check(run == HALF_DIV, "R9 last fall to select rise", run, HALF_DIV);
        if (exp_q.size() == 0) check(0, "R11 unexpected frame", cap, 0);
        else begin
          logic [15:0] e;
          e = exp_q.pop_front();
          check(cap == e, "R6 word bit order", cap, e);
        end
        sel_hi = 1;
      end else if (load_sel) sel_hi++;
      // serial clock phases
      if (ser_clk != p_clk) begin
        if (ser_clk) begin
          if (nbits == 0) check(sel_lo - 1 == HALF_DIV, "R3 select to first edge", sel_lo - 1, HALF_DIV);
          else check(run == HALF_DIV, "R8 low phase", run, HALF_DIV);
          cap = {cap[14:0], ser_dat};
          nbits++;
        end else check(run == HALF_DIV, "R8 high phase", run, HALF_DIV);
        run = 1;
      end else run++;
    end
    p_clk = ser_clk; p_sel = load_sel; p_dat = ser_dat;
  end

  initial begin
    repeat (60000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(load_sel == 1'b1, "R1 reset select", load_sel, 1);
    check(ser_clk == 1'b0, "R1 reset clock", ser_clk, 0);
    check(word_ready == 1'b0, "R1 reset ready", word_ready, 0);
    rst_n = 1'b1;
    begin
      int n = 0;
      while (!word_ready && n < SEL_GAP + 2) begin @(negedge clk); n++; end
      check(word_ready == 1'b1, "R1 ready after reset", word_ready, 1);
    end
    // idle with no request: lines stay put
    repeat (10) @(negedge clk);
    check(load_sel == 1'b1 && ser_clk == 1'b0, "R4 idle lines", {load_sel, ser_clk}, 2'b10);

    send_word(16'hA55A);
    send_word(16'h0000);
    send_word(16'hFFFF);
    send_word(16'h8000);
    send_word(16'h7FFF);
    send_word(16'h00FF);
    send_word(16'hFF00);
    send_word(16'h0001);

    // R11: offer junk while a frame is running
    send_word(16'h1234);
    repeat (6) @(negedge clk);
    word_valid = 1'b1;
    word_data  = 16'hDEAD;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      check(word_ready == 1'b0, "R11 busy while junk offered", word_ready, 0);
    end
    word_valid = 1'b0;
    word_data  = 16'hBEEF;
    send_word(16'h4C3B);

    while (exp_q.size() != 0 || !word_ready) @(negedge clk);
    repeat (20) @(negedge clk);
    check(frames == sent, "R11 frame count", frames, sent);
    check(load_sel == 1'b1, "R9 select high after last word", load_sel, 1);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule